// File: doc/BRIEF.md
# Parallel-Band Graphic Equalizer Datapath

This block is a single-channel, fixed-point graphic equalizer. Every accepted audio sample feeds ten second-order bandpass filters that all see the same input at once. Each filter's result is scaled by its own signed band gain. The scaled results are summed together with a copy of the input that is attenuated by 12 dB. The sum is clamped to the 24-bit range and presented as one output sample.

A single multiplier with a wide accumulator serves every section in turn. Software loads the five filter coefficients and the gain of each band through a simple write port, normally while the block is idle. A new sample is taken only when the block is not busy. The result appears a fixed number of cycles later as a one-cycle strobe.

Top module: `peq_top`

## Requirements
- R1: A configuration write uses the upper address bits `cfg_addr[6:3]` as the band number (0 to 9) and the lower bits `cfg_addr[2:0]` as the field. Field 0 is b0, 1 is b1, 2 is b2, 3 is the halved first feedback coefficient, 4 is the halved second feedback coefficient, and 5 is the band gain. Writes to band numbers of 10 or more, or to fields 6 and 7, change nothing.
- R2: For each band, with all values read as signed Q1.23, the section forms acc = b0·x + b1·x1 + b2·x2 + 2·f1·y1 + 2·f2·y2. It then outputs y = floor(acc / 2^23) clamped to [-2^23, 2^23-1].
- R3: The output sample is clamp(floor((Σ gain_k·y_k + floor(x/4)·2^23) / 2^23)). Between strobes the output holds its last value.
- R4: When all ten band gains are zero, the output equals floor(x/4) whatever the coefficients are.
- R5: A result above 2^23-1 is output as 0x7FFFFF, and a result below -2^23 is output as 0x800000. The output never wraps.
- R6: `out_valid` is high for exactly one cycle. It rises with the 62nd rising edge after the edge that accepted the sample, and `busy` falls with that same edge.
- R7: `busy` rises on the edge after an accepted sample. While `busy` is high, `in_valid` and `in_data` are ignored.
- R8: The history of each band (x1, x2, y1, y2) advances exactly once per accepted sample. It takes effect only after all ten bands have used the old history.
- R9: Synchronous reset clears all band history, both accumulators, the output and `busy`, and sets every band gain to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe, taken when not busy |
| in_data | input | 24 | Signed Q1.23 input sample |
| cfg_we | input | 1 | Coefficient/gain write enable |
| cfg_addr | input | 7 | Band number (bits 6:3) and field (bits 2:0) |
| cfg_data | input | 24 | Signed Q1.23 write value |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 24 | Saturated signed Q1.23 output sample |
| busy | output | 1 | High while a sample is being processed |

## Verification
Every sample's result is due on the 62nd rising edge after the edge that accepted it. `busy` falls and `out_valid` rises on that same edge. `busy` rises on the edge right after the accepting edge. A behavioural model in the bench advances its own cycle counter at each rising edge and predicts `busy`, `out_valid` and `out_data`. The bench samples and compares all three on every falling edge, so each result is checked in the exact cycle it is due. Directed scenarios also compare selected results against hand-computed values: flat response, single-band scaling, saturation, and the value after reset.

// File: rtl/peq_pkg.sv
`timescale 1ns/1ps
package peq_pkg;
  localparam int FLD_W   = 3;
  localparam int NCOEF   = 5;
  localparam logic [FLD_W-1:0] FLD_GAIN = 3'd5;

  typedef enum logic [2:0] {
    M_HOLD, M_BLOAD, M_BACC, M_SACC, M_SADD, M_SCLR
  } mac_op_e;

  typedef enum logic [1:0] {
    S_IDLE, S_FILT, S_PASS, S_OUT
  } seq_st_e;
endpackage

// File: rtl/peq_coef_bank.sv
`timescale 1ns/1ps
module peq_coef_bank #(
  parameter int NBANDS = 10,
  parameter int SW     = 24,
  parameter int BW     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [BW-1:0]        wband,
  input  logic [2:0]           wfield,
  input  logic signed [SW-1:0] wdata,
  input  logic [BW-1:0]        rd_band,
  input  logic [2:0]           rd_field,
  output logic signed [SW-1:0] rd_coef,
  output logic signed [SW-1:0] rd_gain
);
  import peq_pkg::*;

  logic signed [SW-1:0] coef_mem [NBANDS][NCOEF];
  logic signed [SW-1:0] gain_r   [NBANDS];
  logic band_ok;

  assign band_ok = (wband < BW'(NBANDS));

  // coefficient memory: no reset, write-only port plus async read
  always_ff @(posedge clk) begin
    if (we && band_ok && (wfield < 3'(NCOEF)))
      coef_mem[wband][wfield] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBANDS; i++) gain_r[i] <= '0;
    end else if (we && band_ok && (wfield == FLD_GAIN)) begin
      gain_r[wband] <= wdata;
    end
  end

  assign rd_coef = coef_mem[rd_band][rd_field];
  assign rd_gain = gain_r[rd_band];
endmodule

// File: rtl/peq_state_bank.sv
`timescale 1ns/1ps
module peq_state_bank #(
  parameter int NBANDS = 10,
  parameter int SW     = 24,
  parameter int BW     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit,
  input  logic signed [SW-1:0] x_in,
  input  logic                 ywr_en,
  input  logic [BW-1:0]        ywr_band,
  input  logic signed [SW-1:0] ywr_val,
  input  logic [BW-1:0]        rd_band,
  output logic signed [SW-1:0] rd_x1,
  output logic signed [SW-1:0] rd_x2,
  output logic signed [SW-1:0] rd_y1,
  output logic signed [SW-1:0] rd_y2
);
  logic signed [SW-1:0] x1_r [NBANDS];
  logic signed [SW-1:0] x2_r [NBANDS];
  logic signed [SW-1:0] y1_r [NBANDS];
  logic signed [SW-1:0] y2_r [NBANDS];
  logic signed [SW-1:0] yn_r [NBANDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBANDS; i++) begin
        x1_r[i] <= '0; x2_r[i] <= '0;
        y1_r[i] <= '0; y2_r[i] <= '0;
        yn_r[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NBANDS; i++) begin
        if (ywr_en && (ywr_band == BW'(i))) yn_r[i] <= ywr_val;
        if (commit) begin
          x2_r[i] <= x1_r[i];
          x1_r[i] <= x_in;
          y2_r[i] <= y1_r[i];
          y1_r[i] <= yn_r[i];
        end
      end
    end
  end

  assign rd_x1 = x1_r[rd_band];
  assign rd_x2 = x2_r[rd_band];
  assign rd_y1 = y1_r[rd_band];
  assign rd_y2 = y2_r[rd_band];
endmodule

// File: rtl/peq_mac.sv
`timescale 1ns/1ps
module peq_mac #(
  parameter int SW    = 24,
  parameter int GUARD = 8,
  localparam int PW   = 2*SW,
  localparam int AW   = PW + GUARD
) (
  input  logic                 clk,
  input  logic                 rst,
  input  peq_pkg::mac_op_e     op,
  input  logic signed [SW-1:0] op_a,
  input  logic signed [SW-1:0] op_b,
  input  logic                 dbl,
  input  logic signed [AW-1:0] sadd,
  output logic signed [SW-1:0] band_sat,
  output logic signed [SW-1:0] sum_sat
);
  import peq_pkg::*;

  localparam logic signed [AW-1:0] HI = $signed((AW'(1) <<< (SW-1)) - AW'(1));
  localparam logic signed [AW-1:0] LO = $signed(-HI - AW'(1));

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] term;
  logic signed [AW-1:0] acc_b, acc_s;

  function automatic logic signed [SW-1:0] clamp_q(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] s;
    s = v >>> (SW-1);
    if (s > HI)      return HI[SW-1:0];
    else if (s < LO) return LO[SW-1:0];
    else             return s[SW-1:0];
  endfunction

  assign prod = op_a * op_b;
  assign term = dbl ? (AW'(prod) <<< 1) : AW'(prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_b <= '0;
      acc_s <= '0;
    end else begin
      case (op)
        M_BLOAD: acc_b <= term;
        M_BACC:  acc_b <= acc_b + term;
        M_SACC:  acc_s <= acc_s + term;
        M_SADD:  acc_s <= acc_s + sadd;
        M_SCLR:  acc_s <= '0;
        default: ;
      endcase
    end
  end

  assign band_sat = clamp_q(acc_b);
  assign sum_sat  = clamp_q(acc_s);
endmodule

// File: rtl/peq_top.sv
`timescale 1ns/1ps
module peq_top #(
  parameter int NBANDS = 10,
  parameter int SW     = 24,
  parameter int GUARD  = 8,
  localparam int BW    = $clog2(NBANDS + 1),
  localparam int ADRW  = BW + 3,
  localparam int AW    = 2*SW + GUARD
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_data,
  input  logic                 cfg_we,
  input  logic [ADRW-1:0]      cfg_addr,
  input  logic signed [SW-1:0] cfg_data,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_data,
  output logic                 busy
);
  import peq_pkg::*;

  seq_st_e              st;
  logic [BW-1:0]        band;
  logic [2:0]           phase;
  logic signed [SW-1:0] x_cur;

  logic signed [SW-1:0] coef, gain, x1, x2, y1, y2;
  logic signed [SW-1:0] band_sat, sum_sat;
  logic signed [SW-1:0] op_a, op_b;
  logic signed [AW-1:0] pass_term;
  mac_op_e              op;
  logic                 dbl, last_ph;

  assign busy    = (st != S_IDLE);
  assign last_ph = (phase == 3'(NCOEF));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      band      <= '0;
      phase     <= '0;
      x_cur     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          x_cur <= in_data;
          band  <= '0;
          phase <= '0;
          st    <= S_FILT;
        end
        S_FILT: if (last_ph) begin
          phase <= '0;
          if (band == BW'(NBANDS-1)) st <= S_PASS;
          else                       band <= band + 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
        S_PASS: st <= S_OUT;
        default: begin
          out_valid <= 1'b1;
          out_data  <= sum_sat;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  // operand selection and MAC command for the current step
  always_comb begin
    op   = M_HOLD;
    dbl  = 1'b0;
    op_a = coef;
    op_b = x_cur;
    case (phase)
      3'd1:    op_b = x1;
      3'd2:    op_b = x2;
      3'd3:    begin op_b = y1; dbl = 1'b1; end
      3'd4:    begin op_b = y2; dbl = 1'b1; end
      3'd5:    begin op_a = gain; op_b = band_sat; end
      default: op_b = x_cur;
    endcase
    case (st)
      S_IDLE: if (in_valid) op = M_SCLR;
      S_FILT: op = last_ph ? M_SACC : ((phase == 3'd0) ? M_BLOAD : M_BACC);
      S_PASS: op = M_SADD;
      default: op = M_HOLD;
    endcase
  end

  assign pass_term = (AW'(x_cur) >>> 2) <<< (SW-1);

  peq_coef_bank #(.NBANDS(NBANDS), .SW(SW), .BW(BW)) u_coef (
    .clk(clk), .rst(rst), .we(cfg_we),
    .wband(cfg_addr[ADRW-1:3]), .wfield(cfg_addr[2:0]), .wdata(cfg_data),
    .rd_band(band), .rd_field(phase), .rd_coef(coef), .rd_gain(gain)
  );

  peq_state_bank #(.NBANDS(NBANDS), .SW(SW), .BW(BW)) u_state (
    .clk(clk), .rst(rst), .commit(st == S_PASS), .x_in(x_cur),
    .ywr_en((st == S_FILT) && last_ph), .ywr_band(band), .ywr_val(band_sat),
    .rd_band(band), .rd_x1(x1), .rd_x2(x2), .rd_y1(y1), .rd_y2(y2)
  );

  peq_mac #(.SW(SW), .GUARD(GUARD)) u_mac (
    .clk(clk), .rst(rst), .op(op), .op_a(op_a), .op_b(op_b), .dbl(dbl),
    .sadd(pass_term), .band_sat(band_sat), .sum_sat(sum_sat)
  );
endmodule

// File: rtl/peq_chk.sv
`timescale 1ns/1ps
module peq_chk #(
  parameter int LAT = 63
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic busy,
  input logic out_valid
);
  logic [15:0] since_acc;

  always_ff @(posedge clk) begin
    if (rst)                    since_acc <= '0;
    else if (in_valid && !busy) since_acc <= 16'd1;
    else if (out_valid)         since_acc <= '0;
    else if (since_acc != '0)   since_acc <= since_acc + 16'd1;
  end

  // R6
  lat_window_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (since_acc == 16'(LAT)));
  // R6
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R6
  out_idle_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || out_valid));
  // R7
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);
  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !out_valid));
endmodule

bind peq_top peq_chk #(.LAT(NBANDS*6+3)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy), .out_valid(out_valid)
);

// File: tb/peq_top_tb.sv
`timescale 1ns/1ps
module peq_top_tb;
  localparam int NB = 10;
  localparam int LATENCY = 62;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [23:0] in_data = '0;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic signed [23:0] cfg_data = '0;
  logic out_valid;
  logic signed [23:0] out_data;
  logic busy;

  int checks = 0;
  int errors = 0;
  bit cyc_on = 1'b0;

  always #4 clk = ~clk;

  peq_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_data(out_data), .busy(busy)
  );

  // ---------------- behavioural reference ----------------
  longint mc [NB][5];
  longint mg [NB];
  longint mx1 [NB], mx2 [NB], my1 [NB], my2 [NB];
  bit     m_busy, m_outv;
  int     m_cnt;
  longint m_res, m_outd;

  function automatic longint clamp24(longint v);
    if (v > 64'sd8388607)  return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint model_sample(longint x);
    longint sum, acc;
    longint yn [NB];
    sum = 0;
    for (int b = 0; b < NB; b++) begin
      acc = mc[b][0]*x + mc[b][1]*mx1[b] + mc[b][2]*mx2[b]
          + 2*mc[b][3]*my1[b] + 2*mc[b][4]*my2[b];
      yn[b] = clamp24(acc >>> 23);
      sum += mg[b] * yn[b];
    end
    sum += (x >>> 2) <<< 23;
    for (int b = 0; b < NB; b++) begin
      mx2[b] = mx1[b]; mx1[b] = x;
      my2[b] = my1[b]; my1[b] = yn[b];
    end
    return clamp24(sum >>> 23);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_outv = 0; m_cnt = 0; m_outd = 0; m_res = 0;
      for (int b = 0; b < NB; b++) begin
        mg[b] = 0; mx1[b] = 0; mx2[b] = 0; my1[b] = 0; my2[b] = 0;
      end
    end else begin
      m_outv = 0;
      if (cfg_we && (cfg_addr[6:3] < 4'd10)) begin
        if (cfg_addr[2:0] < 3'd5) mc[cfg_addr[6:3]][cfg_addr[2:0]] = longint'(cfg_data);
        else if (cfg_addr[2:0] == 3'd5) mg[cfg_addr[6:3]] = longint'(cfg_data);
      end
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LATENCY) begin
          m_busy = 0; m_outv = 1; m_outd = m_res;
        end
      end else if (in_valid) begin
        m_busy = 1; m_cnt = 0;
        m_res = model_sample(longint'(in_data));
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (cyc_on && !rst) begin
      chk("R6 out_valid timing", longint'(out_valid), longint'(m_outv));
      chk("R7 busy", longint'(busy), longint'(m_busy));
      chk("R3 out_data", longint'(out_data), m_outd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int band, int field, longint val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'((band << 3) | field); cfg_data = 24'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(longint x, output longint res);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1; in_data = 24'(x);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    res = longint'(out_data);
  endtask

  task automatic run_model(longint x, string tag);
    longint r;
    run(x, r);
    chk(tag, r, m_outd);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 out_data after reset", longint'(out_data), 0);
    chk("R9 busy after reset", longint'(busy), 0);
    chk("R9 out_valid after reset", longint'(out_valid), 0);
    for (int b = 0; b < NB; b++)
      for (int f = 0; f < 5; f++) wr(b, f, 0);
    cyc_on = 1'b1;

    // R4 flat response with zero gains, even with nonzero coefficients
    wr(4, 0, 24'sh3FFFFF); wr(7, 3, 24'sh200000);
    run(1000, r);      chk("R4 flat +1000", r, 250);
    run(-1001, r);     chk("R4 flat -1001", r, -251);
    run(8388607, r);   chk("R4 flat max", r, 2097151);
    wr(4, 0, 0); wr(7, 3, 0);
    run(0, r); run(0, r); run(0, r);

    // R2 single band: b0 = 0.5, gain = 0.5
    wr(3, 0, 24'sh400000); wr(3, 5, 24'sh400000);
    run(4096, r);      chk("R2 single band", r, 2048);
    wr(3, 1, 24'sh200000); wr(3, 2, -24'sh100000);
    wr(6, 0, 24'sh600000); wr(6, 5, -24'sh300000);
    run_model(300000, "R2 two bands n0");
    run_model(-120000, "R2 two bands n1");
    run_model(55555, "R2 two bands n2");

    // R1 writes to absent bands / fields are ignored
    wr(12, 0, 24'sh7FFFFF); wr(2, 6, 24'sh7FFFFF); wr(1, 7, 24'sh7FFFFF);
    run_model(70000, "R1 ignored writes");

    // R8 feedback history: f1 stored 0.375 -> 0.75 effective
    wr(3, 1, 0); wr(3, 2, 0); wr(6, 5, 0);
    wr(3, 3, 24'sh300000); wr(3, 4, -24'sh080000);
    run_model(1000000, "R8 impulse");
    for (int k = 0; k < 5; k++) run_model(0, "R8 ringing");
    wr(3, 3, 0); wr(3, 4, 0);

    // R5 saturation both ways
    for (int b = 0; b < NB; b++) begin wr(b, 0, 24'sh7FFFFF); wr(b, 5, 24'sh7FFFFF); end
    run(8388607, r);   chk("R5 clamp high", r, 8388607);
    run(-8388608, r);  chk("R5 clamp low", r, -8388608);

    // R7 input ignored while busy
    for (int b = 0; b < NB; b++) begin wr(b, 0, 24'sh100000); wr(b, 5, 24'sh080000); end
    @(negedge clk);
    in_valid = 1'b1; in_data = 24'sd200000;
    @(negedge clk);
    in_data = -24'sd777777;
    repeat (40) @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    chk("R7 busy input ignored", longint'(out_data), m_outd);
    chk("R7 no extra accept", longint'(busy), 0);

    // R9 reset clears gains and history
    @(negedge clk); rst = 1'b1; cyc_on = 1'b0;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk); cyc_on = 1'b1;
    run(400, r);       chk("R9 gains cleared", r, 100);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule